// File: doc/BRIEF.md
# Hypercube Dimension-Ordered Route Unit

This block walks a packet's path through a binary n-cube of 2^n nodes. A route is opened by presenting a source node and a destination node on a start strobe. From then on the unit offers one hop at a time on a valid/ready pair. Each hop names, as a one-hot vector, the cube dimension whose link is to be crossed next. The dimension chosen is always the lowest bit position in which the current node and the destination still disagree. Addresses are therefore corrected strictly from bit 0 upward.

Each accepted hop flips that bit of the tracked current node. When the current node reaches the destination the unit raises a one-cycle done flag, which stands for ejection at the local port. The number of hops the route will take is the Hamming distance between source and destination, which is at most n. It is computed once when the route opens and held on a distance output. A consumer that keeps ready high gets one hop per clock cycle.

Top module: `ecube_router`

## Requirements
- R1: While reset (active-low `rst_n`) is asserted, and after it is released with no start, `hop_valid_o`, `route_done_o`, `hop_dim_o`, `cur_node_o` and `dist_o` are all zero.
- R2: A start accepted at a clock edge makes `cur_node_o` equal to the source and `dist_o` equal to the number of bit positions in which source and destination differ, both from the next cycle on.
- R3: While a route is open and the current node differs from the destination, `hop_valid_o` is 1 and `hop_dim_o` has exactly one bit set: bit i, where i is the lowest position in which the current node and the destination differ. Otherwise `hop_dim_o` is zero.
- R4: A hop is taken at a clock edge where `hop_valid_o` and `hop_ready_i` are both 1. The current node then has the selected bit inverted. With `hop_ready_i` low, the current node and the offered hop stay unchanged.
- R5: On the cycle after the final hop, `route_done_o` is 1 for exactly one cycle, `cur_node_o` equals the destination and `hop_valid_o` is 0.
- R6: When source equals destination, `route_done_o` is 1 on the cycle after the start, `dist_o` is 0, and no hop is ever offered.
- R7: The number of hops taken over a route equals `dist_o`, and that number never exceeds the cube dimension `DIM_W`.
- R8: A start presented while a route still has hops outstanding is ignored: the destination, current node and distance stay as they were. A start is accepted when idle or in the done cycle.
- R9: Dimensions are corrected in ascending order. In a 4-cube, routing 0000 to 0111 visits 0001, then 0011, then 0111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Open a route with `src_i` and `dst_i` |
| src_i | input | DIM_W | Source node address |
| dst_i | input | DIM_W | Destination node address |
| hop_valid_o | output | 1 | A hop is offered on `hop_dim_o` |
| hop_ready_i | input | 1 | Consumer takes the offered hop |
| hop_dim_o | output | DIM_W | One-hot dimension to traverse, zero when no hop |
| cur_node_o | output | DIM_W | Node the route currently sits at |
| route_done_o | output | 1 | One-cycle pulse: destination reached, eject |
| dist_o | output | $clog2(DIM_W+1) | Hamming distance of the current route |

## Verification
The bench builds the unit with the default `DIM_W` of 4, a 16-node cube. At this size every one of the 256 source and destination pairs can be routed exhaustively. That sweep covers the zero-hop case, the full-diameter four-hop case and every ascending correction order. The hop consumer stalls on a repeating pattern, so each route mixes back-to-back hops with held hops. A separate run keeps ready low while a second start arrives, to show that start is ignored mid-route.

// File: rtl/ecube_pkg.sv
package ecube_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ROUTE = 2'd1,
    ST_DONE  = 2'd2
  } route_state_e;

  // Isolates the lowest set bit of a word (two's-complement trick).
  function automatic logic [31:0] lowest_one(input logic [31:0] v);
    return v & (~v + 32'd1);
  endfunction

endpackage

// File: rtl/ecube_dim_select.sv
module ecube_dim_select #(
  parameter int unsigned DIM_W = 4
) (
  input  logic [DIM_W-1:0] diff_i,
  output logic [DIM_W-1:0] pick_o,
  output logic             any_o
);
  // seen[i] is set when some lower bit of diff_i is already 1.
  logic [DIM_W:0] seen;

  assign seen[0] = 1'b0;

  generate
    for (genvar i = 0; i < DIM_W; i++) begin : g_chain
      assign pick_o[i]  = diff_i[i] & ~seen[i];
      assign seen[i+1]  = seen[i] | diff_i[i];
    end
  endgenerate

  assign any_o = seen[DIM_W];
endmodule

// File: rtl/ecube_hamming.sv
module ecube_hamming #(
  parameter int unsigned DIM_W = 4,
  parameter int unsigned CNT_W = 3
) (
  input  logic [DIM_W-1:0] diff_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] acc [DIM_W+1];

  assign acc[0] = '0;

  generate
    for (genvar i = 0; i < DIM_W; i++) begin : g_sum
      assign acc[i+1] = acc[i] + CNT_W'(diff_i[i]);
    end
  endgenerate

  assign count_o = acc[DIM_W];
endmodule

// File: rtl/ecube_router.sv
module ecube_router #(
  parameter int unsigned DIM_W = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic [DIM_W-1:0]             src_i,
  input  logic [DIM_W-1:0]             dst_i,
  output logic                         hop_valid_o,
  input  logic                         hop_ready_i,
  output logic [DIM_W-1:0]             hop_dim_o,
  output logic [DIM_W-1:0]             cur_node_o,
  output logic                         route_done_o,
  output logic [$clog2(DIM_W+1)-1:0]   dist_o
);
  import ecube_pkg::*;

  localparam int unsigned CNT_W = $clog2(DIM_W + 1);

  route_state_e     state_q;
  logic [DIM_W-1:0] cur_q;
  logic [DIM_W-1:0] dst_q;
  logic [CNT_W-1:0] dist_q;

  // Named internal events, also observed by the bound checker.
  logic [DIM_W-1:0] diff_w;
  logic [DIM_W-1:0] pick_w;
  logic             more_w;
  logic [CNT_W-1:0] start_dist_w;
  logic             hop_fire_w;
  logic             last_hop_w;
  logic             start_take_w;

  assign diff_w = cur_q ^ dst_q;

  ecube_dim_select #(.DIM_W(DIM_W)) u_pick (
    .diff_i (diff_w),
    .pick_o (pick_w),
    .any_o  (more_w)
  );

  ecube_hamming #(.DIM_W(DIM_W), .CNT_W(CNT_W)) u_dist (
    .diff_i  (src_i ^ dst_i),
    .count_o (start_dist_w)
  );

  assign hop_valid_o  = (state_q == ST_ROUTE) && more_w;
  assign hop_dim_o    = hop_valid_o ? pick_w : '0;
  assign hop_fire_w   = hop_valid_o && hop_ready_i;
  assign last_hop_w   = hop_fire_w && (diff_w == pick_w);
  assign start_take_w = start_i && (state_q != ST_ROUTE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      dst_q   <= '0;
      dist_q  <= '0;
    end else if (start_take_w) begin
      cur_q   <= src_i;
      dst_q   <= dst_i;
      dist_q  <= start_dist_w;
      state_q <= (start_dist_w == '0) ? ST_DONE : ST_ROUTE;
    end else begin
      case (state_q)
        ST_ROUTE: begin
          if (hop_fire_w) begin
            cur_q <= cur_q ^ pick_w;
            if (last_hop_w) state_q <= ST_DONE;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cur_node_o   = cur_q;
  assign route_done_o = (state_q == ST_DONE);
  assign dist_o       = dist_q;
endmodule

// File: rtl/ecube_router_chk.sv
module ecube_router_chk #(
  parameter int unsigned DIM_W = 4,
  parameter int unsigned CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             hop_valid_o,
  input logic             hop_ready_i,
  input logic [DIM_W-1:0] hop_dim_o,
  input logic [DIM_W-1:0] cur_node_o,
  input logic             route_done_o,
  input logic [CNT_W-1:0] dist_o,
  input logic [DIM_W-1:0] dst_q,
  input logic [DIM_W-1:0] diff_w,
  input logic             hop_fire_w,
  input logic             start_take_w
);
  // Hops taken since the last accepted start.
  logic [CNT_W-1:0] hop_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            hop_cnt <= '0;
    else if (start_take_w) hop_cnt <= '0;
    else if (hop_fire_w)   hop_cnt <= hop_cnt + CNT_W'(1);
  end

  p_dim_lowest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hop_valid_o |-> ($onehot(hop_dim_o) && ((hop_dim_o & diff_w) == hop_dim_o)
                     && (((hop_dim_o - DIM_W'(1)) & diff_w) == '0)));

  p_dim_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !hop_valid_o |-> (hop_dim_o == '0));

  p_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hop_fire_w |=> (cur_node_o == ($past(cur_node_o) ^ $past(hop_dim_o))));

  p_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hop_valid_o && !hop_ready_i) |=> ($stable(cur_node_o) && hop_valid_o));

  p_done_at_dst_r5: assert property (@(posedge clk) disable iff (!rst_n)
    route_done_o |-> ((cur_node_o == dst_q) && !hop_valid_o));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (route_done_o && !start_i) |=> !route_done_o);

  p_hop_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    route_done_o |-> ((hop_cnt == dist_o) && (dist_o <= CNT_W'(DIM_W))));

  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hop_valid_o && start_i) |=> ($stable(dist_o) && $stable(dst_q)));
endmodule

bind ecube_router ecube_router_chk #(.DIM_W(DIM_W), .CNT_W(CNT_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .hop_valid_o  (hop_valid_o),
  .hop_ready_i  (hop_ready_i),
  .hop_dim_o    (hop_dim_o),
  .cur_node_o   (cur_node_o),
  .route_done_o (route_done_o),
  .dist_o       (dist_o),
  .dst_q        (dst_q),
  .diff_w       (diff_w),
  .hop_fire_w   (hop_fire_w),
  .start_take_w (start_take_w)
);

// File: tb/ecube_router_tb.sv
module ecube_router_tb_top;
  localparam int unsigned W  = 4;
  localparam int unsigned CW = $clog2(W + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [W-1:0]  src_i = '0;
  logic [W-1:0]  dst_i = '0;
  logic          hop_valid_o;
  logic          hop_ready_i = 1'b0;
  logic [W-1:0]  hop_dim_o;
  logic [W-1:0]  cur_node_o;
  logic          route_done_o;
  logic [CW-1:0] dist_o;

  int checks = 0;
  int bad = 0;
  int cyc = 0;
  logic ready_hold = 1'b0;

  // Scoreboard: expected hop dimension and the node it departs from.
  logic [W-1:0] exp_dim_q[$];
  logic [W-1:0] exp_cur_q[$];

  always #2.5 clk = ~clk;

  ecube_router #(.DIM_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .src_i(src_i), .dst_i(dst_i),
    .hop_valid_o(hop_valid_o), .hop_ready_i(hop_ready_i), .hop_dim_o(hop_dim_o),
    .cur_node_o(cur_node_o), .route_done_o(route_done_o), .dist_o(dist_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Consumer ready: stalls one cycle in three, changed just after the edge.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 hop_ready_i = !ready_hold && ((cyc % 3) != 1);
  end

  // Monitor: compare each offered hop with the scoreboard head.
  always @(negedge clk) begin
    if (rst_n && hop_valid_o) begin
      if (exp_dim_q.size() == 0) begin
        check(1'b0, "R7", "hop offered beyond expected count", int'(hop_dim_o), 0);
      end else begin
        check(hop_dim_o == exp_dim_q[0], "R3", "hop dimension", int'(hop_dim_o), int'(exp_dim_q[0]));
        check(cur_node_o == exp_cur_q[0], "R4", "current node before hop", int'(cur_node_o), int'(exp_cur_q[0]));
        if (hop_ready_i) begin
          void'(exp_dim_q.pop_front());
          void'(exp_cur_q.pop_front());
        end
      end
    end
  end

  function automatic int popc(input logic [W-1:0] v);
    int n = 0;
    for (int i = 0; i < W; i++) n += int'(v[i]);
    return n;
  endfunction

  // Driver: open a route and push the expected hops, lowest bit first.
  task automatic launch(input logic [W-1:0] s, input logic [W-1:0] d);
    logic [W-1:0] c;
    c = s;
    for (int i = 0; i < W; i++) begin
      if (c[i] != d[i]) begin
        exp_dim_q.push_back(W'(1) << i);
        exp_cur_q.push_back(c);
        c[i] = ~c[i];
      end
    end
    @(negedge clk);
    start_i = 1'b1; src_i = s; dst_i = d;
    @(negedge clk);
    start_i = 1'b0;
    check(cur_node_o == s, "R2", "current node after start", int'(cur_node_o), int'(s));
    check(int'(dist_o) == popc(s ^ d), "R2", "distance", int'(dist_o), popc(s ^ d));
    check(int'(dist_o) <= W, "R7", "distance within diameter", int'(dist_o), W);
  endtask

  task automatic finish_route(input logic [W-1:0] d, input bit zero_hop);
    int waited = 0;
    if (zero_hop) begin
      check(route_done_o == 1'b1, "R6", "done right after start", int'(route_done_o), 1);
      check(hop_valid_o == 1'b0, "R6", "no hop offered", int'(hop_valid_o), 0);
    end
    while (!route_done_o && waited < 40) begin
      @(negedge clk);
      waited++;
    end
    check(route_done_o == 1'b1, "R5", "done raised", int'(route_done_o), 1);
    check(cur_node_o == d, "R5", "arrived at destination", int'(cur_node_o), int'(d));
    check(hop_valid_o == 1'b0, "R5", "no hop while done", int'(hop_valid_o), 0);
    check(exp_dim_q.size() == 0, "R7", "hops left in scoreboard", exp_dim_q.size(), 0);
    exp_dim_q.delete();
    exp_cur_q.delete();
    @(negedge clk);
    check(route_done_o == 1'b0, "R5", "done lasts one cycle", int'(route_done_o), 0);
  endtask

  // Watchdog.
  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!hop_valid_o && !route_done_o && hop_dim_o == 0 && cur_node_o == 0 && dist_o == 0,
          "R1", "outputs in reset", int'(hop_valid_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!hop_valid_o && !route_done_o && hop_dim_o == 0 && cur_node_o == 0 && dist_o == 0,
          "R1", "idle after reset", int'(route_done_o), 0);

    // R9: ascending correction order 0000 -> 0001 -> 0011 -> 0111.
    launch(4'b0000, 4'b0111);
    finish_route(4'b0111, 1'b0);

    // R8: start mid-route with ready held low is ignored.
    ready_hold = 1'b1;
    launch(4'b0000, 4'b1111);
    @(negedge clk);
    start_i = 1'b1; src_i = 4'b0011; dst_i = 4'b0011;
    @(negedge clk);
    start_i = 1'b0;
    check(int'(dist_o) == 4, "R8", "distance kept", int'(dist_o), 4);
    check(cur_node_o == 4'b0000, "R8", "current node kept", int'(cur_node_o), 0);
    check(hop_valid_o == 1'b1, "R8", "route still open", int'(hop_valid_o), 1);
    ready_hold = 1'b0;
    finish_route(4'b1111, 1'b0);

    // Exhaustive sweep over every source/destination pair (R2..R7).
    for (int s = 0; s < (1 << W); s++) begin
      for (int d = 0; d < (1 << W); d++) begin
        launch(W'(s), W'(d));
        finish_route(W'(d), s == d);
      end
    end

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule